// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits beside the fetch stage of a pipelined processor and tells it, in the same cycle as the fetch address is presented, where to fetch next. It keeps a direct-mapped table. The table is indexed by the word-aligned program counter, so the two lowest address bits take no part in indexing. Each entry holds a valid bit, an address tag, a two-bit saturating direction counter and the last taken target. When the fetch address hits a valid entry, the counter's upper bit gives the direction. A predicted-taken hit steers fetch straight to the stored target, with no penalty cycle. When the address misses, a fallback rule is applied if the fetch stage has predecoded a branch: a target at or below the branch address is treated as a loop and predicted taken, and a target above it is predicted not taken.

Branches are resolved later in the pipeline, and the result comes back through an update port. That port carries the branch address, the real outcome, the real target and the next address that was predicted for that branch at fetch. The block trains or allocates the entry. One cycle later it raises a single-cycle mispredict pulse if the real next address differs from the predicted one, and the pipeline uses this pulse to flush.

Top module: `branch_target_predictor`

## Requirements
- R1: After reset every entry is invalid, so every fetch address misses (`hit_o` = 0).
- R2: The index is `pc[IDX_W+1:2]` and the tag is `pc[ADDR_W-1:IDX_W+2]`. A fetch hits only when the entry at its index is valid and its stored tag equals the fetch tag. Two addresses with the same index but different tags do not hit on each other's entry.
- R3: An update to an address with no matching entry allocates the entry. The counter starts at 2'b10 (weakly taken) if the branch was taken and at 2'b01 (weakly not taken) if it was not. The given target is stored in both cases.
- R4: An update that hits moves the counter up by one on taken and down by one on not taken. The counter saturates at 2'b11 and 2'b00. On a hit, counter values 2'b10 and 2'b11 predict taken and 2'b00 and 2'b01 predict not taken.
- R5: From a strong state (2'b11 or 2'b00), a single opposite outcome does not change the predicted direction. Two opposite outcomes in a row do change it.
- R6: A hit predicted taken gives `next_pc_o` equal to the stored target. An update that hits refreshes the stored target only when the outcome is taken.
- R7: A fetch predicted not taken gives `next_pc_o` = `fetch_pc_i` + 4.
- R8: On a miss with `fetch_br_i` = 1, the fetch is predicted taken with `next_pc_o` = `fetch_br_tgt_i` when that target is not greater than `fetch_pc_i` (unsigned). Otherwise it is predicted not taken. On a miss with `fetch_br_i` = 0, the fetch is predicted not taken.
- R9: `mispredict_o` is high for exactly the one cycle after an update whose real next address differs from `upd_pred_next_i`. The real next address is `upd_target_i` when the branch was taken and `upd_pc_i` + 4 when it was not. At all other times `mispredict_o` is low.
- R10: An update whose tag differs from the valid entry at its index replaces that entry. The old address then misses.
- R11: An update takes effect at the next clock edge. A fetch in the same cycle as the update sees the table as it was before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | ADDR_W | Current fetch address |
| fetch_br_i | input | 1 | Predecode marks the fetched word as a branch |
| fetch_br_tgt_i | input | ADDR_W | Predecoded branch target, used on a miss |
| hit_o | output | 1 | Fetch address matched a valid entry |
| pred_taken_o | output | 1 | Predicted direction |
| next_pc_o | output | ADDR_W | Predicted next fetch address |
| upd_valid_i | input | 1 | A resolved branch is reported this cycle |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome |
| upd_target_i | input | ADDR_W | Resolved target |
| upd_pred_next_i | input | ADDR_W | Next address predicted for this branch at fetch |
| mispredict_o | output | 1 | One-cycle flush request after a wrong prediction |

## Verification
The bench builds the block with 8 entries and 32-bit addresses. Random fetch and update addresses are drawn from four tags over those 8 indices, so aliasing, entry replacement and counter saturation at both ends occur many times within a few thousand cycles. Directed sequences cover the reset miss, allocation in both directions, hysteresis, target refresh, a fetch in the same cycle as an update, and all three fallback cases on a miss.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  function automatic ctr_e ctr_init(input logic taken);
    return taken ? CTR_WT : CTR_WNT;
  endfunction

  function automatic ctr_e ctr_step(input ctr_e c, input logic taken);
    if (taken) return (c == CTR_ST) ? CTR_ST : ctr_e'(c + 2'd1);
    else       return (c == CTR_SNT) ? CTR_SNT : ctr_e'(c - 2'd1);
  endfunction

  function automatic logic ctr_taken(input ctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output ctr_e              rd_ctr_o,
  output logic [ADDR_W-1:0] rd_tgt_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic              wr_taken_i,
  input  logic [ADDR_W-1:0] wr_tgt_i
);

  logic [ENTRIES-1:0]             valid_w;
  logic [ENTRIES-1:0][TAG_W-1:0]  tag_w;
  ctr_e [ENTRIES-1:0]             ctr_w;
  logic [ENTRIES-1:0][ADDR_W-1:0] tgt_w;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    ctr_e              c_q;
    logic [ADDR_W-1:0] g_q;
    logic              sel;
    logic              same;

    assign sel  = wr_en_i && (wr_idx_i == IDX_W'(e));
    assign same = v_q && (t_q == wr_tag_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  v_q <= 1'b0;
      else if (sel) v_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) begin
        t_q <= wr_tag_i;
        c_q <= same ? ctr_step(c_q, wr_taken_i) : ctr_init(wr_taken_i);
        // keep the last taken target while training an existing entry
        if (!same || wr_taken_i) g_q <= wr_tgt_i;
      end
    end

    assign valid_w[e] = v_q;
    assign tag_w[e]   = t_q;
    assign ctr_w[e]   = c_q;
    assign tgt_w[e]   = g_q;
  end

  assign rd_valid_o = valid_w[rd_idx_i];
  assign rd_tag_o   = tag_w[rd_idx_i];
  assign rd_ctr_o   = ctr_w[rd_idx_i];
  assign rd_tgt_o   = tgt_w[rd_idx_i];

  logic wr_same;
  assign wr_same = valid_w[wr_idx_i] && (tag_w[wr_idx_i] == wr_tag_i);

  // R3
  alloc_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_w[$past(wr_idx_i)]);

  // R3
  alloc_ctr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_same) |=>
      (ctr_w[$past(wr_idx_i)] == ($past(wr_taken_i) ? CTR_WT : CTR_WNT)));

  // R4
  ctr_sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_same && wr_taken_i && ctr_w[wr_idx_i] == CTR_ST) |=>
      (ctr_w[$past(wr_idx_i)] == CTR_ST));

  // R4
  ctr_sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_same && !wr_taken_i && ctr_w[wr_idx_i] == CTR_SNT) |=>
      (ctr_w[$past(wr_idx_i)] == CTR_SNT));

endmodule

// File: rtl/bp_lookup.sv
module bp_lookup
  import bp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              fetch_br_i,
  input  logic [ADDR_W-1:0] fetch_br_tgt_i,
  output logic [IDX_W-1:0]  rd_idx_o,
  input  logic              rd_valid_i,
  input  logic [TAG_W-1:0]  rd_tag_i,
  input  ctr_e              rd_ctr_i,
  input  logic [ADDR_W-1:0] rd_tgt_i,
  output logic              hit_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] next_pc_o
);

  logic [ADDR_W-1:0] seq_pc;
  logic              static_taken;

  assign rd_idx_o     = fetch_pc_i[IDX_W+1:2];
  assign seq_pc       = fetch_pc_i + ADDR_W'(4);
  assign hit_o        = rd_valid_i && (rd_tag_i == fetch_pc_i[ADDR_W-1:IDX_W+2]);
  // backward (or self) branches are assumed to close a loop
  assign static_taken = fetch_br_i && (fetch_br_tgt_i <= fetch_pc_i);

  always_comb begin
    if (hit_o) begin
      taken_o   = ctr_taken(rd_ctr_i);
      next_pc_o = taken_o ? rd_tgt_i : seq_pc;
    end else begin
      taken_o   = static_taken;
      next_pc_o = static_taken ? fetch_br_tgt_i : seq_pc;
    end
  end

  // R7
  fallthru_chk: assert final (taken_o || next_pc_o == fetch_pc_i + ADDR_W'(4));

endmodule

// File: rtl/bp_mispredict.sv
module bp_mispredict #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [ADDR_W-1:0] upd_pred_next_i,
  output logic              mispredict_o
);

  logic [ADDR_W-1:0] actual_next;
  logic              mis_q;

  assign actual_next = upd_taken_i ? upd_target_i : upd_pc_i + ADDR_W'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mis_q <= 1'b0;
    else         mis_q <= upd_valid_i && (actual_next != upd_pred_next_i);
  end

  assign mispredict_o = mis_q;

  // R9
  mis_needs_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mispredict_o |-> $past(upd_valid_i));

endmodule

// File: rtl/branch_target_predictor.sv
module branch_target_predictor
  import bp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int TAG_W  = ADDR_W - IDX_W - 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] fetch_pc_i,
  input  logic              fetch_br_i,
  input  logic [ADDR_W-1:0] fetch_br_tgt_i,
  output logic              hit_o,
  output logic              pred_taken_o,
  output logic [ADDR_W-1:0] next_pc_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [ADDR_W-1:0] upd_pred_next_i,
  output logic              mispredict_o
);

  logic [IDX_W-1:0]  rd_idx;
  logic              rd_valid;
  logic [TAG_W-1:0]  rd_tag;
  ctr_e              rd_ctr;
  logic [ADDR_W-1:0] rd_tgt;

  bp_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (rd_idx),
    .rd_valid_o (rd_valid),
    .rd_tag_o   (rd_tag),
    .rd_ctr_o   (rd_ctr),
    .rd_tgt_o   (rd_tgt),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_pc_i[IDX_W+1:2]),
    .wr_tag_i   (upd_pc_i[ADDR_W-1:IDX_W+2]),
    .wr_taken_i (upd_taken_i),
    .wr_tgt_i   (upd_target_i)
  );

  bp_lookup #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_lookup (
    .fetch_pc_i     (fetch_pc_i),
    .fetch_br_i     (fetch_br_i),
    .fetch_br_tgt_i (fetch_br_tgt_i),
    .rd_idx_o       (rd_idx),
    .rd_valid_i     (rd_valid),
    .rd_tag_i       (rd_tag),
    .rd_ctr_i       (rd_ctr),
    .rd_tgt_i       (rd_tgt),
    .hit_o          (hit_o),
    .taken_o        (pred_taken_o),
    .next_pc_o      (next_pc_o)
  );

  bp_mispredict #(.ADDR_W(ADDR_W)) u_mis (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .upd_valid_i     (upd_valid_i),
    .upd_pc_i        (upd_pc_i),
    .upd_taken_i     (upd_taken_i),
    .upd_target_i    (upd_target_i),
    .upd_pred_next_i (upd_pred_next_i),
    .mispredict_o    (mispredict_o)
  );

  // R11
  upd_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_valid_i) && fetch_pc_i == $past(upd_pc_i)) |-> hit_o);

  // R6
  taken_hit_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(upd_valid_i) && $past(upd_taken_i) && fetch_pc_i == $past(upd_pc_i) && pred_taken_o)
      |-> next_pc_o == $past(upd_target_i));

endmodule

// File: tb/tb_branch_target_predictor.sv
module tb_branch_target_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int ENTRIES = 8;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int TW = AW - IW - 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0, fetch_br_tgt = '0;
  logic          fetch_br = 1'b0;
  logic          hit, ptaken, mis;
  logic [AW-1:0] next_pc;
  logic          upd_valid = 1'b0, upd_taken = 1'b0;
  logic [AW-1:0] upd_pc = '0, upd_target = '0, upd_pred = '0;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  branch_target_predictor #(.ENTRIES(ENTRIES), .ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_pc_i(fetch_pc), .fetch_br_i(fetch_br), .fetch_br_tgt_i(fetch_br_tgt),
    .hit_o(hit), .pred_taken_o(ptaken), .next_pc_o(next_pc),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken),
    .upd_target_i(upd_target), .upd_pred_next_i(upd_pred),
    .mispredict_o(mis)
  );

  // reference state built from the requirements
  bit            m_v[ENTRIES];
  logic [TW-1:0] m_t[ENTRIES];
  logic [1:0]    m_c[ENTRIES];
  logic [AW-1:0] m_g[ENTRIES];
  bit            exp_mis = 0;

  function automatic int idx_of(input logic [AW-1:0] pc);
    return int'(pc[IW+1:2]);
  endfunction

  function automatic bit m_hit(input logic [AW-1:0] pc);
    return m_v[idx_of(pc)] && m_t[idx_of(pc)] == pc[AW-1:IW+2];
  endfunction

  function automatic bit m_taken(input logic [AW-1:0] pc, input bit br, input logic [AW-1:0] bt);
    if (m_hit(pc)) return m_c[idx_of(pc)][1];
    return br && (bt <= pc);
  endfunction

  function automatic logic [AW-1:0] m_next(input logic [AW-1:0] pc, input bit br, input logic [AW-1:0] bt);
    if (!m_taken(pc, br, bt)) return pc + 4;
    return m_hit(pc) ? m_g[idx_of(pc)] : bt;
  endfunction

  task automatic chk(input string rq, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step(input logic [AW-1:0] fpc, input bit fbr, input logic [AW-1:0] fbt,
                      input bit uv, input logic [AW-1:0] upc, input bit utk,
                      input logic [AW-1:0] ut, input logic [AW-1:0] upn, input string rq);
    bit nm;
    int i;
    bit h;
    @(negedge clk);
    fetch_pc = fpc; fetch_br = fbr; fetch_br_tgt = fbt;
    upd_valid = uv; upd_pc = upc; upd_taken = utk; upd_target = ut; upd_pred = upn;
    #1;
    chk({rq, " hit"},   AW'(hit),    AW'(m_hit(fpc)));
    chk({rq, " taken"}, AW'(ptaken), AW'(m_taken(fpc, fbr, fbt)));
    chk({rq, " next"},  next_pc,     m_next(fpc, fbr, fbt));
    chk("R9 mispredict", AW'(mis), AW'(exp_mis));
    nm = uv && ((utk ? ut : upc + 4) != upn);
    @(posedge clk);
    if (uv) begin
      i = idx_of(upc);
      h = m_hit(upc);
      if (h) begin
        if (utk) m_c[i] = (m_c[i] == 2'b11) ? 2'b11 : m_c[i] + 2'd1;
        else     m_c[i] = (m_c[i] == 2'b00) ? 2'b00 : m_c[i] - 2'd1;
        if (utk) m_g[i] = ut;
      end else begin
        m_c[i] = utk ? 2'b10 : 2'b01;
        m_g[i] = ut;
      end
      m_v[i] = 1; m_t[i] = upc[AW-1:IW+2];
    end
    exp_mis = nm;
  endtask

  task automatic fetch_only(input logic [AW-1:0] fpc, input string rq);
    step(fpc, 0, '0, 0, '0, 0, '0, '0, rq);
  endtask

  task automatic upd(input logic [AW-1:0] pc, input bit tk, input logic [AW-1:0] tg,
                     input logic [AW-1:0] pn, input string rq);
    step(pc, 0, '0, 1, pc, tk, tg, pn, rq);
  endtask

  localparam logic [AW-1:0] PA = 32'h0000_0040;
  localparam logic [AW-1:0] PB = 32'h0000_0044;
  localparam logic [AW-1:0] PC_ALIAS = 32'h0000_0060; // same index as PA
  localparam logic [AW-1:0] PD = 32'h0000_004c;

  initial begin
    for (int k = 0; k < ENTRIES; k++) m_v[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: every index misses after reset
    for (int k = 0; k < ENTRIES; k++) fetch_only(AW'(k * 4 + 32'h200), "R1");

    // R3: allocate taken and not-taken, mispredict pulse
    upd(PA, 1, 32'h800, PA + 4, "R3");
    fetch_only(PA, "R3 R6");
    upd(PB, 0, 32'h900, PB + 4, "R3");
    fetch_only(PB, "R3 R7");

    // R4 R5: saturate high, one not-taken keeps taken
    upd(PA, 1, 32'h800, 32'h800, "R4");
    upd(PA, 1, 32'h800, 32'h800, "R4");
    upd(PA, 0, 32'h800, 32'h800, "R5");
    fetch_only(PA, "R5");
    upd(PA, 0, 32'h804, 32'h800, "R5");
    fetch_only(PA, "R5 R7");
    upd(PA, 0, 32'h804, PA + 4, "R4");
    upd(PA, 0, 32'h804, PA + 4, "R4");
    upd(PA, 1, 32'hA00, PA + 4, "R5");
    fetch_only(PA, "R5");

    // R6: taken refresh vs not-taken keep
    upd(PA, 1, 32'hB00, PA + 4, "R6");
    upd(PA, 1, 32'hC00, 32'hB00, "R6");
    upd(PA, 0, 32'hD00, 32'hC00, "R6");
    fetch_only(PA, "R6");

    // R2 R10: alias replaces entry
    upd(PC_ALIAS, 0, 32'h100, PC_ALIAS + 4, "R10");
    fetch_only(PA, "R2 R10");
    fetch_only(PC_ALIAS, "R10");

    // R11: same-cycle fetch sees old state
    step(PD, 0, '0, 1, PD, 1, 32'h20, PD + 4, "R11");
    fetch_only(PD, "R11");

    // R8: static rule on misses
    step(32'h1000, 1, 32'h0F00, 0, '0, 0, '0, '0, "R8");
    step(32'h1000, 1, 32'h1000, 0, '0, 0, '0, '0, "R8");
    step(32'h1000, 1, 32'h1100, 0, '0, 0, '0, '0, "R8");
    step(32'h1000, 0, 32'h0F00, 0, '0, 0, '0, '0, "R8");

    // random mix over 4 tags x 8 indices
    void'($urandom(32'd20240607));
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] fp, up, ut, ub, pn;
      bit tk;
      fp = AW'((($urandom % 4) << 5) | (($urandom % 8) << 2)) + 32'h400;
      up = AW'((($urandom % 4) << 5) | (($urandom % 8) << 2)) + 32'h400;
      ut = {$urandom, 2'b00} & 32'h0000_0FFC;
      ub = {$urandom, 2'b00} & 32'h0000_0FFC;
      tk = ($urandom % 3) != 0;
      pn = ($urandom % 2) ? (tk ? ut : up + 4) : ({$urandom, 2'b00} & 32'h0000_0FFC);
      step(fp, ($urandom % 2) == 1, ub, ($urandom % 4) != 0, up, tk, ut, pn, "R2 R4 R6 R7 R8");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule